// File: doc/BRIEF.md
# Configurable Logic Cell with Four Macrocells

This block is one programmable logic cell of a small complex-PLD fabric. It takes eighteen routed input signals and forms product terms from them in a programmable AND array. Each term may use the true form of an input, its complement, or neither. The sum terms feed four macrocells. Each macrocell picks one of two paths. The narrow path is the OR of four terms that belong to that macrocell. The wide path is the OR of any subset of the twenty sum terms, followed by a programmable XOR inversion. Each macrocell can present this sum directly or through a flip-flop.

Three further product terms drive control functions. The first is a clock that the cell can use in place of one of the three global clock pins. The second is an asynchronous clear for the four flip-flops. The third is an output-enable signal that goes on to the I/O cells.

The whole personality of the cell is a single configuration vector. It is shifted in serially on the system clock while `cfg_load` is high. Until a complete load has finished, every logic output stays at 0. This also holds after reset and during a reload.

Top module: `glb_cell`

## Requirements
- R1: While `cfg_load` is high, each rising `clk` edge shifts `cfg_din` into the top of the configuration vector, and the whole vector moves one place toward bit 0. After CFG_W shifts, the first bit sent sits at bit 0. With the default sizes CFG_W is 922.
- R2: After reset, and from the first `clk` edge with `cfg_load` high, `mc_out` and `pt_oe` read 0 and the flip-flops are held clear. Normal operation resumes on the `clk` edge after `cfg_load` is sampled low following a load. Reset also clears the configuration vector.
- R3: Product term t is described by the 36 bits starting at bit 36*t. Bit 2k selects input k in true form, and bit 2k+1 selects input k in complemented form. The term is the AND of its selected literals. A term with no bit set reads 0, and a term that uses both forms of one input reads 0. Terms 0 to 19 are sum terms.
- R4: Each macrocell i has a 23-bit field starting at bit 828+23*i. When its wide-select bit (field bit 21) is 0, its sum is the OR of terms 4i to 4i+3.
- R5: When the wide-select bit is 1, the sum is the OR of those sum terms whose bit is set in the field's 20-bit mask (field bits 0 to 19, bit j selecting term j). This OR is XOR-ed with the polarity bit (field bit 20). Terms left out of the mask have no effect.
- R6: When the registered bit (field bit 22) is 0, `mc_out[i]` follows the sum combinationally. When it is 1, `mc_out[i]` shows a flip-flop that loads the sum on the rising edge of the cell clock and holds it otherwise. Each macrocell is set independently.
- R7: The 2-bit clock select at bits 921:920 picks the cell clock. Values 0, 1 and 2 pick `gclk[0]`, `gclk[1]` and `gclk[2]`. Value 3 picks product term 20. Clock sources that are not selected have no effect.
- R8: Product term 21, or a low `rst_n`, clears all four flip-flops to 0 at once, without waiting for a clock edge.
- R9: `pt_oe` equals product term 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for configuration shifting |
| rst_n | input | 1 | Global active-low asynchronous reset |
| cfg_load | input | 1 | High while configuration bits are shifted in |
| cfg_din | input | 1 | Serial configuration data |
| gclk | input | 3 | Global clock pins |
| in_bus | input | 18 | Routed logic inputs |
| mc_out | output | 4 | Macrocell outputs |
| pt_oe | output | 1 | Product-term output enable toward the I/O cells |

## Verification
The bench builds the cell with its default sizes: eighteen inputs, four macrocells, four bypass terms per macrocell and twenty sum terms. These sizes produce the 922-bit configuration layout that the bench assembles on its own.

With twenty sum terms, a wide-path mask can take a term from another macrocell's bypass group while leaving out a term that is active. This lets the bench check both term selection and the XOR inversion. The four-term bypass groups allow an empty group and a self-contradicting term to be placed next to a working group.

The three global clock pins together with the product-term clock let the bench check each clock source against the others that are not selected.

// File: rtl/glb_pkg.sv
package glb_pkg;

   // Source of the shared macrocell clock
   typedef enum logic [1:0] {
      SRC_Y0 = 2'd0,
      SRC_Y1 = 2'd1,
      SRC_Y2 = 2'd2,
      SRC_PT = 2'd3
   } clk_src_e;

   // Control product terms placed after the sum terms
   localparam int CTRL_PT  = 3;
   localparam int CTRL_CLK = 0;
   localparam int CTRL_RST = 1;
   localparam int CTRL_OE  = 2;

   // Per-macrocell flag bits after the wide-path mask
   localparam int MC_FLAGS = 3;
   localparam int FLG_POL  = 0;
   localparam int FLG_WIDE = 1;
   localparam int FLG_REG  = 2;

   localparam int SEL_W = 2;

endpackage

// File: rtl/glb_cfg_chain.sv
module glb_cfg_chain #(
   parameter int CFG_W = 922
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             din,
   output logic [CFG_W-1:0] cfg,
   output logic             valid
);

   logic busy;

   if (CFG_W < 2) begin : g_bad_w
      $error("glb_cfg_chain: CFG_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= '0;
         valid <= 1'b0;
         busy  <= 1'b0;
      end else if (load) begin
         cfg   <= {din, cfg[CFG_W-1:1]};
         valid <= 1'b0;
         busy  <= 1'b1;
      end else if (busy) begin
         valid <= 1'b1;
         busy  <= 1'b0;
      end
   end

   // R1
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cfg[CFG_W-1] == $past(din))
      else $error("serial bit not captured");

   // R2
   load_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !valid)
      else $error("config marked valid during load");

   // R2
   load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> valid)
      else $error("config not valid after load");

endmodule

// File: rtl/glb_and_array.sv
module glb_and_array #(
   parameter int N_IN = 18,
   parameter int N_PT = 23
) (
   input  logic [N_IN-1:0]        in_bus,
   input  logic [N_PT*2*N_IN-1:0] row_cfg,
   output logic [N_PT-1:0]        terms
);

   localparam int ROW_W = 2 * N_IN;

   logic [ROW_W-1:0] lits;

   always_comb begin
      for (int k = 0; k < N_IN; k++) begin
         lits[2*k]   = in_bus[k];
         lits[2*k+1] = ~in_bus[k];
      end
   end

   for (genvar t = 0; t < N_PT; t++) begin : g_term
      logic [ROW_W-1:0] row;
      logic             contra;

      assign row      = row_cfg[t*ROW_W +: ROW_W];
      assign terms[t] = (|row) & (&(lits | ~row));

      always_comb begin
         contra = 1'b0;
         for (int k = 0; k < N_IN; k++) begin
            contra = contra | (row[2*k] & row[2*k+1]);
         end
      end

      always_comb begin
         if (contra) begin
            // R3
            contra_term_chk: assert (terms[t] == 1'b0)
               else $error("contradicting term reads 1");
         end
      end
   end

endmodule

// File: rtl/glb_macrocell.sv
module glb_macrocell #(
   parameter int N_PT   = 20,
   parameter int BYP_PT = 4,
   parameter int IDX    = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_PT-1:0] terms,
   input  logic [N_PT-1:0] mask,
   input  logic            pol,
   input  logic            wide,
   input  logic            regd,
   input  logic            blk_clk,
   input  logic            clr,
   output logic            mc_q
);

   logic byp_sum;
   logic wide_sum;
   logic d;
   logic q;

   if ((IDX + 1) * BYP_PT > N_PT) begin : g_bad_idx
      $error("glb_macrocell: bypass group outside term range");
   end

   assign byp_sum  = |terms[IDX*BYP_PT +: BYP_PT];
   assign wide_sum = (|(terms & mask)) ^ pol;
   assign d        = wide ? wide_sum : byp_sum;

   always_ff @(posedge blk_clk or posedge clr) begin
      if (clr) q <= 1'b0;
      else     q <= d;
   end

   assign mc_q = regd ? q : d;

   // R8
   held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && $past(clr)) |-> (q == 1'b0))
      else $error("flip-flop not held clear");

endmodule

// File: rtl/glb_cell.sv
module glb_cell
   import glb_pkg::*;
#(
   parameter int N_IN     = 18,
   parameter int N_MC     = 4,
   parameter int BYP_PT   = 4,
   parameter int N_SUM_PT = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_load,
   input  logic            cfg_din,
   input  logic [2:0]      gclk,
   input  logic [N_IN-1:0] in_bus,
   output logic [N_MC-1:0] mc_out,
   output logic            pt_oe
);

   localparam int ROW_W = 2 * N_IN;
   localparam int N_PT  = N_SUM_PT + CTRL_PT;
   localparam int ARR_W = N_PT * ROW_W;
   localparam int MC_W  = N_SUM_PT + MC_FLAGS;
   localparam int MC_B  = ARR_W;
   localparam int SEL_B = ARR_W + N_MC * MC_W;
   localparam int CFG_W = SEL_B + SEL_W;

   if (N_SUM_PT < N_MC * BYP_PT) begin : g_bad_pt
      $error("glb_cell: too few sum terms for bypass groups");
   end
   if (N_IN < 1 || N_MC < 1) begin : g_bad_size
      $error("glb_cell: empty cell");
   end

   logic [CFG_W-1:0] cfg;
   logic             cfg_valid;
   logic [N_PT-1:0]  terms;
   logic [N_MC-1:0]  mc_raw;
   clk_src_e         src;
   logic             blk_clk;
   logic             clr;

   glb_cfg_chain #(.CFG_W(CFG_W)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cfg_load),
      .din   (cfg_din),
      .cfg   (cfg),
      .valid (cfg_valid)
   );

   glb_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_array (
      .in_bus  (in_bus),
      .row_cfg (cfg[ARR_W-1:0]),
      .terms   (terms)
   );

   assign src = clk_src_e'(cfg[SEL_B +: SEL_W]);

   always_comb begin
      case (src)
         SRC_Y0:  blk_clk = gclk[0];
         SRC_Y1:  blk_clk = gclk[1];
         SRC_Y2:  blk_clk = gclk[2];
         default: blk_clk = terms[N_SUM_PT + CTRL_CLK];
      endcase
   end

   assign clr = ~rst_n | ~cfg_valid | terms[N_SUM_PT + CTRL_RST];

   for (genvar i = 0; i < N_MC; i++) begin : g_mc
      localparam int BASE = MC_B + i * MC_W;

      glb_macrocell #(.N_PT(N_SUM_PT), .BYP_PT(BYP_PT), .IDX(i)) u_mc (
         .clk     (clk),
         .rst_n   (rst_n),
         .terms   (terms[N_SUM_PT-1:0]),
         .mask    (cfg[BASE +: N_SUM_PT]),
         .pol     (cfg[BASE + N_SUM_PT + FLG_POL]),
         .wide    (cfg[BASE + N_SUM_PT + FLG_WIDE]),
         .regd    (cfg[BASE + N_SUM_PT + FLG_REG]),
         .blk_clk (blk_clk),
         .clr     (clr),
         .mc_q    (mc_raw[i])
      );
   end

   assign mc_out = cfg_valid ? mc_raw : '0;
   assign pt_oe  = cfg_valid & terms[N_SUM_PT + CTRL_OE];

   // R2
   load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (mc_out == '0 && !pt_oe))
      else $error("outputs active during load");

endmodule

// File: tb/glb_cell_test.sv
module glb_cell_test;

   localparam int CFG_W = 922;
   localparam int ROW   = 36;
   localparam int MCB   = 828;
   localparam int MCW   = 23;
   localparam int SELB  = 920;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic        cfg_din = 1'b0;
   logic [2:0]  gclk = 3'b000;
   logic [17:0] in_bus = '0;
   logic [3:0]  mc_out;
   logic        pt_oe;

   logic [CFG_W-1:0] img;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   glb_cell uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_din(cfg_din),
      .gclk(gclk), .in_bus(in_bus), .mc_out(mc_out), .pt_oe(pt_oe)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic lit(input int t, input int k, input bit comp);
      img[t*ROW + 2*k + (comp ? 1 : 0)] = 1'b1;
   endtask

   task automatic mc(input int i, input logic [19:0] mask, input bit pol,
                     input bit wide, input bit regd);
      img[MCB + i*MCW +: 20] = mask;
      img[MCB + i*MCW + 20]  = pol;
      img[MCB + i*MCW + 21]  = wide;
      img[MCB + i*MCW + 22]  = regd;
   endtask

   // Shift img in, bit 0 first; peek>=0 checks quiet outputs mid-load
   task automatic load_cfg(input int peek);
      for (int b = 0; b < CFG_W; b++) begin
         @(negedge clk);
         if (b == peek) begin
            chk("R2 quiet during load", {27'd0, pt_oe, mc_out}, 32'd0);
         end
         cfg_load = 1'b1;
         cfg_din  = img[b];
      end
      @(negedge clk);
      cfg_load = 1'b0;
      cfg_din  = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse(input int p);
      gclk[p] = 1'b1;
      #3;
      gclk[p] = 1'b0;
      #3;
   endtask

   function automatic logic [4:0] model_a(input logic [17:0] v);
      logic e0, e2, e3;
      e0 = v[0] & ~v[1];
      e2 = ~(e0 | v[3]);
      e3 = v[3] | v[4];
      return {v[6], e3, e2, 1'b0, e0};
   endfunction

   task automatic t_reset;
      @(negedge clk);
      chk("R2 reset state", {27'd0, pt_oe, mc_out}, 32'd0);
      in_bus = '1;
      #1;
      chk("R2 unconfigured", {27'd0, pt_oe, mc_out}, 32'd0);
      in_bus = '0;
   endtask

   task automatic build_a;
      img = '0;
      lit(0, 0, 0); lit(0, 1, 1);   // term0 = in0 & ~in1
      lit(4, 2, 0); lit(4, 2, 1);   // term4 contradicts
      lit(12, 3, 0);                // term12 = in3
      lit(13, 4, 0);                // term13 = in4
      lit(16, 5, 0);                // term16 = in5, kept out of mask
      lit(22, 6, 0);                // output enable = in6
      mc(0, 20'h0, 0, 0, 0);
      mc(1, 20'h0, 0, 0, 0);
      mc(2, 20'h01001, 1, 1, 0);
      mc(3, 20'h0, 0, 0, 0);
   endtask

   task automatic t_comb_array;
      logic [17:0] vecs [10];
      logic [4:0]  e;
      vecs = '{18'h0, 18'h1, 18'h3, 18'h2, 18'h8, 18'h10, 18'h18, 18'h20, 18'h44, 18'h3FFFF};
      build_a();
      load_cfg(-1);
      foreach (vecs[n]) begin
         @(negedge clk);
         in_bus = vecs[n];
         #1;
         e = model_a(vecs[n]);
         chk("R3 term literals mc0", {31'd0, mc_out[0]}, {31'd0, e[0]});
         chk("R3 empty/contradicting mc1", {31'd0, mc_out[1]}, 32'd0);
         chk("R5 wide mask xor mc2", {31'd0, mc_out[2]}, {31'd0, e[2]});
         chk("R4 bypass group mc3", {31'd0, mc_out[3]}, {31'd0, e[3]});
         chk("R9 output enable", {31'd0, pt_oe}, {31'd0, e[4]});
      end
   endtask

   task automatic t_reload_quiet;
      @(negedge clk);
      in_bus = '0;
      #1;
      chk("R5 inverted empty sum", {28'd0, mc_out}, 32'h4);
      load_cfg(40);
      in_bus = 18'h1;
      #1;
      chk("R1 reloaded image", {28'd0, mc_out}, 32'h1);
   endtask

   task automatic t_global_clock;
      img = '0;
      lit(0, 0, 0);      // term0 = in0
      lit(12, 3, 0);     // term12 = in3
      lit(21, 7, 0);     // clear term = in7
      mc(0, 20'h0, 0, 0, 1);
      mc(3, 20'h0, 0, 0, 0);
      img[SELB] = 1'b1;  // select gclk[1]
      img[SELB+1] = 1'b0;
      @(negedge clk);
      in_bus = '0;
      load_cfg(-1);
      pulse(1);
      in_bus[0] = 1'b1;
      in_bus[3] = 1'b1;
      #1;
      chk("R6 comb mc3 follows", {31'd0, mc_out[3]}, 32'd1);
      chk("R6 reg mc0 waits", {31'd0, mc_out[0]}, 32'd0);
      pulse(0);
      pulse(2);
      chk("R7 unselected pins ignored", {31'd0, mc_out[0]}, 32'd0);
      pulse(1);
      chk("R7 selected pin captures", {31'd0, mc_out[0]}, 32'd1);
      in_bus[0] = 1'b0;
      #1;
      chk("R6 reg holds", {31'd0, mc_out[0]}, 32'd1);
      in_bus[7] = 1'b1;
      #1;
      chk("R8 term clear async", {31'd0, mc_out[0]}, 32'd0);
      @(negedge clk);
      in_bus[7] = 1'b0;
      #1;
      chk("R8 stays cleared", {31'd0, mc_out[0]}, 32'd0);
      in_bus[0] = 1'b1;
      pulse(1);
      chk("R6 recapture", {31'd0, mc_out[0]}, 32'd1);
      #1;
      rst_n = 1'b0;
      #1;
      chk("R8 reset pin clears", {28'd0, mc_out}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      pulse(1);
      #1;
      chk("R2 blank after reset", {27'd0, pt_oe, mc_out}, 32'd0);
      in_bus = '0;
   endtask

   task automatic t_term_clock;
      img = '0;
      lit(0, 0, 0);      // term0 = in0
      lit(20, 8, 0);     // clock term = in8
      mc(0, 20'h0, 0, 0, 1);
      img[SELB] = 1'b1;
      img[SELB+1] = 1'b1;
      @(negedge clk);
      in_bus = '0;
      load_cfg(-1);
      in_bus[0] = 1'b1;
      #1;
      chk("R7 no edge yet", {31'd0, mc_out[0]}, 32'd0);
      in_bus[8] = 1'b1;
      #1;
      chk("R7 term clock captures", {31'd0, mc_out[0]}, 32'd1);
      in_bus[0] = 1'b0;
      #1;
      pulse(0);
      pulse(1);
      pulse(2);
      chk("R7 pins ignored in term mode", {31'd0, mc_out[0]}, 32'd1);
      in_bus[8] = 1'b0;
      #1;
      chk("R7 falling edge ignored", {31'd0, mc_out[0]}, 32'd1);
      in_bus[8] = 1'b1;
      #1;
      chk("R7 second term edge", {31'd0, mc_out[0]}, 32'd0);
   endtask

   initial begin
      img = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_comb_array();
      t_reload_quiet();
      t_global_clock();
      t_term_clock();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule